// File: doc/BRIEF.md
# IEC 60958 Channel Status Sequencer

This block supplies the per-frame channel-status bit for each of the two channels, the validity bit, and a block-start marker to a consumer-audio serial transmitter. Each channel has its own 64-bit status word, given as a low and a high 32-bit half. Because the words are separate, the two channels can differ, for example in the channel-number field at bits 20 to 23. A frame tick from the encoder advances a frame counter that runs from 0 to 191. On each tick the block registers the status bit for that frame index. Indices 0 to 31 come from the low half and indices 32 to 63 come from the high half. Indices 64 to 191 send zero.

The block-start output is high during frame 0, so the encoder can choose the block preamble. Status words are captured into shadow registers on the tick of frame 0. A configuration change in the middle of a block therefore changes nothing until the next block begins. The validity output is the programmed validity value when the send-validity enable is set, and 0 otherwise. It is captured on every tick.

Within the status word, the positions that matter to the software that fills it are these:
- Bit 0: professional (1) or consumer (0).
- Bit 1: non-PCM.
- Bit 2: copy permitted.
- Bit 3: pre-emphasis.
- Bits 8 to 15: category, made of a 3-bit group, a 4-bit code and the generation bit.
- Bits 16 to 19: source number.
- Bits 24 to 27: sample-rate code, for example 48 kHz = 0x2.
- Bits 28 to 29: clock accuracy.

The sequencer sends these bits in index order and does not interpret any of them.

Top module: `iec_cs_sequencer`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) sets the frame index to 0 and drives cs_left, cs_right, v_out and block_start to 0 from the next cycle.
- R2: All outputs change only at a clock edge where frame_tick is high. Otherwise they hold their values.
- R3: On a tick at frame index k, where 0 <= k <= 31, cs_left and cs_right become bit k of the active low word of their own channel.
- R4: On a tick at frame index k, where 32 <= k <= 63, cs_left and cs_right become bit k-32 of the active high word of their own channel.
- R5: On a tick at frame index 64 to 191, cs_left and cs_right become 0.
- R6: The frame index advances by one on each tick and wraps from 191 to 0. block_start becomes 1 on the tick at index 0 and becomes 0 on every other tick.
- R7: The left and right outputs are taken only from their own channel's words, so different words give different bit streams.
- R8: On each tick, v_out becomes cfg_v_value if cfg_v_send is 1, and becomes 0 otherwise.
- R9: The four configuration words are sampled only on the tick at index 0 and are used for that whole block. Words changed at any other time take effect from the next block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_tick | input | 1 | One-cycle pulse per frame |
| cfg_left_lo | input | 32 | Left status bits 0 to 31 |
| cfg_left_hi | input | 32 | Left status bits 32 to 63 |
| cfg_right_lo | input | 32 | Right status bits 0 to 31 |
| cfg_right_hi | input | 32 | Right status bits 32 to 63 |
| cfg_v_value | input | 1 | Programmed validity value |
| cfg_v_send | input | 1 | Enables validity sending |
| cs_left | output | 1 | Left channel-status bit for the current frame |
| cs_right | output | 1 | Right channel-status bit for the current frame |
| v_out | output | 1 | Validity bit for the current frame |
| block_start | output | 1 | High during frame 0 of a block |

## Verification
The case that is hardest to reach from the ports is a configuration change in the middle of a block. That change must leave the rest of the block alone and must appear exactly at the next frame 0. The stimulus therefore rewrites all four words partway through a block, while ticks are arriving with irregular gaps. The reference model then detects any frame that uses the new words too early.

The stimulus also applies a reset in the middle of a block, which forces the index back to frame 0. It uses different left and right channel numbers, so a swap between the channels would be caught.

// File: rtl/iec_cs_sequencer.sv
module iec_cs_sequencer #(
  parameter int FRAMES = 192,
  parameter int WORD   = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            frame_tick,
  input  logic [WORD-1:0] cfg_left_lo,
  input  logic [WORD-1:0] cfg_left_hi,
  input  logic [WORD-1:0] cfg_right_lo,
  input  logic [WORD-1:0] cfg_right_hi,
  input  logic            cfg_v_value,
  input  logic            cfg_v_send,
  output logic            cs_left,
  output logic            cs_right,
  output logic            v_out,
  output logic            block_start
);
  localparam int STATUS_BITS = 2 * WORD;
  localparam int IW = $clog2(FRAMES);
  localparam int SW = $clog2(STATUS_BITS);
  localparam logic [IW-1:0] LAST = IW'(FRAMES - 1);
  localparam logic [IW-1:0] SB   = IW'(STATUS_BITS);

  logic [IW-1:0]          idx;
  logic [STATUS_BITS-1:0] sh_l, sh_r;

  wire at_start = (idx == '0);
  wire [STATUS_BITS-1:0] use_l = at_start ? {cfg_left_hi, cfg_left_lo}   : sh_l;
  wire [STATUS_BITS-1:0] use_r = at_start ? {cfg_right_hi, cfg_right_lo} : sh_r;
  wire in_word = (idx < SB);
  wire [SW-1:0] bsel = idx[SW-1:0];
  wire bit_l = in_word & use_l[bsel];
  wire bit_r = in_word & use_r[bsel];

  always_ff @(posedge clk) begin
    if (rst) begin
      idx         <= '0;
      sh_l        <= '0;
      sh_r        <= '0;
      cs_left     <= 1'b0;
      cs_right    <= 1'b0;
      v_out       <= 1'b0;
      block_start <= 1'b0;
    end else if (frame_tick) begin
      if (at_start) begin
        sh_l <= use_l;
        sh_r <= use_r;
      end
      cs_left     <= bit_l;
      cs_right    <= bit_r;
      v_out       <= cfg_v_send & cfg_v_value;
      block_start <= at_start;
      idx         <= (idx == LAST) ? '0 : idx + 1'b1;
    end
  end

  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (idx == '0) && !cs_left && !cs_right && !v_out && !block_start);

  // R2
  a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
    !frame_tick |=> $stable({cs_left, cs_right, v_out, block_start, idx}));

  // R5
  a_r5_tail_zero: assert property (@(posedge clk) disable iff (rst)
    (frame_tick && !in_word) |=> !cs_left && !cs_right);

  // R6
  a_r6_start_flag: assert property (@(posedge clk) disable iff (rst)
    frame_tick |=> (block_start == ($past(idx) == '0)));

  a_r6_index_range: assert property (@(posedge clk) disable iff (rst)
    idx <= LAST);

  a_r6_wrap: assert property (@(posedge clk) disable iff (rst)
    (frame_tick && idx == LAST) |=> idx == '0);

  // R8
  a_r8_validity: assert property (@(posedge clk) disable iff (rst)
    frame_tick |=> v_out == ($past(cfg_v_send) && $past(cfg_v_value)));

  // R9
  a_r9_shadow_stable: assert property (@(posedge clk) disable iff (rst)
    !(frame_tick && at_start) |=> $stable({sh_l, sh_r}));
endmodule

// File: tb/tb_iec_cs_sequencer.sv
module tb_iec_cs_sequencer;
  logic clk = 0;
  logic rst = 1;
  logic frame_tick = 0;
  logic [31:0] cfg_left_lo = 0, cfg_left_hi = 0, cfg_right_lo = 0, cfg_right_hi = 0;
  logic cfg_v_value = 0, cfg_v_send = 0;
  logic cs_left, cs_right, v_out, block_start;

  always #4 clk = ~clk;

  iec_cs_sequencer dut (
    .clk(clk), .rst(rst), .frame_tick(frame_tick),
    .cfg_left_lo(cfg_left_lo), .cfg_left_hi(cfg_left_hi),
    .cfg_right_lo(cfg_right_lo), .cfg_right_hi(cfg_right_hi),
    .cfg_v_value(cfg_v_value), .cfg_v_send(cfg_v_send),
    .cs_left(cs_left), .cs_right(cs_right), .v_out(v_out),
    .block_start(block_start)
  );

  int checks = 0, fails = 0, cycles = 0;
  string phase = "R1";

  // Reference model: frame counter, block-captured words
  int m_idx = 0, m_last = 0;
  logic [63:0] m_l = 0, m_r = 0;
  logic m_cl = 0, m_cr = 0, m_v = 0, m_bs = 0, m_ticked = 0, m_rst = 0;

  function automatic logic pick(logic [63:0] w, int k);
    if (k < 64) return w[k];
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    cycles++;
    m_ticked = 0;
    m_rst = rst;
    if (rst) begin
      m_idx = 0; m_l = 0; m_r = 0;
      m_cl = 0; m_cr = 0; m_v = 0; m_bs = 0;
    end else if (frame_tick) begin
      m_ticked = 1;
      if (m_idx == 0) begin
        m_l = {cfg_left_hi, cfg_left_lo};
        m_r = {cfg_right_hi, cfg_right_lo};
      end
      m_last = m_idx;
      m_cl = pick(m_l, m_idx);
      m_cr = pick(m_r, m_idx);
      m_bs = (m_idx == 0);
      m_v  = cfg_v_send & cfg_v_value;
      m_idx = (m_idx == 191) ? 0 : m_idx + 1;
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s t=%0t act=%b exp=%b", tag, $time, act, exp);
    end
  endtask

  function automatic string cs_tag();
    if (m_rst) return "R1";
    if (!m_ticked) return "R2";
    if (m_last < 32) return "R3";
    if (m_last < 64) return "R4";
    return "R5";
  endfunction

  always @(negedge clk) begin
    string t;
    t = cs_tag();
    chk({phase, "/", t, " cs_left"},  cs_left,  m_cl);
    chk({phase, "/", t, " cs_right"}, cs_right, m_cr);
    chk({phase, "/", m_rst ? "R1" : (m_ticked ? "R8" : "R2"), " v_out"}, v_out, m_v);
    chk({phase, "/", m_rst ? "R1" : (m_ticked ? "R6" : "R2"), " block_start"}, block_start, m_bs);
  end

  always @(negedge clk) begin
    if (cycles > 100000) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic frames(int n, int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); frame_tick = 1;
      @(negedge clk); frame_tick = 0;
      for (int g = 0; g < gap; g++) @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    phase = "R3";
    cfg_left_lo  = 32'h0214_0005; cfg_left_hi  = 32'hA5A5_0F0F;
    cfg_right_lo = 32'h0224_0005; cfg_right_hi = 32'h5A5A_F0F0;
    cfg_v_send = 1; cfg_v_value = 1;
    frames(192, 0);
    phase = "R7";
    cfg_left_lo = 32'hFFFF_FFFF; cfg_right_lo = 32'h0000_0000;
    cfg_left_hi = 32'h0000_0000; cfg_right_hi = 32'hFFFF_FFFF;
    cfg_v_send = 0;
    frames(100, 1);
    phase = "R9";
    cfg_left_lo = 32'h1234_5678; cfg_left_hi = 32'h9ABC_DEF0;
    cfg_right_lo = 32'h0FED_CBA9; cfg_right_hi = 32'h8765_4321;
    cfg_v_send = 1; cfg_v_value = 0;
    frames(92, 2);
    frames(20, 0);
    cfg_left_lo = 32'hDEAD_BEEF;
    cfg_v_value = 1;
    frames(172, 0);
    frames(70, 0);
    phase = "R1";
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    phase = "R6";
    frames(200, 0);
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule